// File: doc/BRIEF.md
# Cascadable 16-bit Timer Chain

This block holds four up-counting 16-bit timers that sit side by side on a small register port. Each timer has two parts. One is a reload value. The other is a control halfword that selects a clock divider, a chained mode, an interrupt enable and a run bit. Software reads back the control halfword and the live count in a single 32-bit word.

A free-running timer advances once per divided clock tick. A chained timer ignores its divider and advances once each time its lower neighbour wraps past 0xFFFF. A wrap can ripple through the whole chain within one clock, so all four timers can roll over on the same edge. Every wrap gives a one-cycle overflow strobe. Sound and DMA logic can use that strobe as a sample or transfer trigger. The same wrap also gives an interrupt strobe when interrupts are enabled for that timer.

Top module: `tmr_chain`

## Requirements
- R1: While reset is held, and right after it, every count, reload and control value reads 0, and both strobe vectors are 0.
- R2: A write of only the low half (`wr_lo`) stores the reload value and leaves a running count untouched. The count keeps stepping from where it was.
- R3: On the edge where a control write turns the run bit (bit 7 of the control halfword) from 0 to 1, the count takes the reload value. If the same write also carries a low half, that new value is used.
- R4: The divider field (control bits 1:0) selects 0 → every clock, 1 → every 64 clocks, 2 → every 256 clocks and 3 → every 1024 clocks. The divider restarts when the timer is started.
- R5: A timer that is not chained wraps exactly div × (0x10000 − reload) clocks after its start edge. On that wrap its count takes the reload value.
- R6: A wrap drives `ovf_pulse[i]` high for the following cycle. `irq_pulse[i]` rises with it only when the interrupt-enable bit (control bit 6) is set, and never rises without the overflow strobe.
- R7: A timer whose chain bit (control bit 2) is set ignores its divider. It steps by 1 exactly once per wrap of the timer below it, and it wraps to 0, not to its reload value.
- R8: A chained wrap ripples up in the same clock: three chained timers at 0xFFFF above timer 0 all strobe overflow on the same cycle as timer 0.
- R9: Timer 0 has no lower neighbour, so with its chain bit set it never steps. A wrap of timer 3 feeds no other timer.
- R10: The read word for the timer picked by `rd_sel` has the control halfword in bits 31:16 and the live count in bits 15:0. Control bits 15:8 and 5:3 read as 0.
- R11: A control write that keeps the run bit at 1 does not reload the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Timer addressed by the write |
| wr_lo | input | 1 | Write updates the reload value from `wr_data[15:0]` |
| wr_hi | input | 1 | Write updates the control halfword from `wr_data[31:16]` |
| wr_data | input | 32 | Write data: control in the upper half, reload in the lower half |
| rd_sel | input | 2 | Timer shown on `rd_data` |
| rd_data | output | 32 | Control halfword (31:16) and live count (15:0), combinational |
| ovf_pulse | output | 4 | One-cycle overflow strobe per timer |
| irq_pulse | output | 4 | One-cycle interrupt strobe per timer |

## Verification
Writes land on the clock edge that samples `wr_en`. A new count or control value can therefore be read through `rd_data` 1 ns after that edge, with no extra cycle. A wrap that happens on edge N shows on the strobes just after edge N, so the bench steps one edge at a time and samples 1 ns after each edge. It counts edges from the start write to the first strobe, and compares that count with div × (0x10000 − reload). Chained checks compare strobes and counts on the very edge where timer 0 wraps, and on the edge after it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control halfword field positions (software decodes these)
  localparam int CTL_RUN_BIT   = 7;
  localparam int CTL_IRQ_BIT   = 6;
  localparam int CTL_CHAIN_BIT = 2;

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic       chain;
    logic [1:0] psc;
  } tmr_ctrl_t;

  function automatic tmr_ctrl_t ctrl_unpack(input logic [15:0] h);
    tmr_ctrl_t c;
    c.run    = h[CTL_RUN_BIT];
    c.irq_en = h[CTL_IRQ_BIT];
    c.chain  = h[CTL_CHAIN_BIT];
    c.psc    = h[1:0];
    return c;
  endfunction

  function automatic logic [15:0] ctrl_pack(input tmr_ctrl_t c);
    return {8'h00, c.run, c.irq_en, 3'b000, c.chain, c.psc};
  endfunction

  // log2 of the divide ratio for each divider code
  function automatic int psc_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 6;
      2'd2:    return 8;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PSC_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       active,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] mask;

  // all-ones mask of the selected width; a full-width mask wraps the counter
  assign mask = PSC_W'((1 << psc_shift(sel)) - 1);
  assign tick = active & ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clear)  div_q <= '0;
    else if (active) div_q <= div_q + PSC_W'(1);
  end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [CNT_W-1:0] lo_data,
  input  logic [15:0]      hi_data,
  input  logic             carry_in,
  output logic             wrap,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [15:0]      ctrl_o,
  output logic             ovf_o,
  output logic             irq_o
);

  tmr_ctrl_t        ctrl_q, ctrl_new;
  logic [CNT_W-1:0] cnt_q, rld_q, load_val;
  logic             start, tick, step;

  assign ctrl_new = ctrl_unpack(hi_data);
  assign start    = wr_hi & ctrl_new.run & ~ctrl_q.run;
  assign load_val = wr_lo ? lo_data : rld_q;

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .active (ctrl_q.run & ~ctrl_q.chain),
    .sel    (ctrl_q.psc),
    .tick   (tick)
  );

  // chained timers step on the neighbour's wrap, others on the divided tick
  assign step = ctrl_q.run & (ctrl_q.chain ? carry_in : tick);
  assign wrap = step & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_lo) rld_q  <= lo_data;
      if (wr_hi) ctrl_q <= ctrl_new;
      if (start)     cnt_q <= load_val;
      else if (wrap) cnt_q <= ctrl_q.chain ? '0 : rld_q;
      else if (step) cnt_q <= cnt_q + CNT_W'(1);
      ovf_o <= wrap;
      irq_o <= wrap & ctrl_q.irq_en;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
  assign ctrl_o   = ctrl_pack(ctrl_q);

endmodule

// File: rtl/tmr_chain.sv
module tmr_chain
  import tmr_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16,
  parameter int PSC_W   = 10,
  localparam int SEL_W  = $clog2(NUM_TMR),
  localparam int WORD_W = 16 + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [NUM_TMR-1:0] ovf_pulse,
  output logic [NUM_TMR-1:0] irq_pulse
);

  logic [NUM_TMR-1:0]            wrap_v;
  logic [NUM_TMR-1:0]            chain_v;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v;
  logic [NUM_TMR-1:0][CNT_W-1:0] rld_v;
  logic [NUM_TMR-1:0][15:0]      ctrl_v;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic carry;
    logic hit;

    if (i == 0) begin : g_head
      assign carry = 1'b0;
    end else begin : g_link
      assign carry = wrap_v[i-1];
    end

    assign hit        = wr_en & (wr_sel == SEL_W'(i));
    assign chain_v[i] = ctrl_v[i][CTL_CHAIN_BIT];

    tmr_unit #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (hit & wr_lo),
      .wr_hi    (hit & wr_hi),
      .lo_data  (wr_data[CNT_W-1:0]),
      .hi_data  (wr_data[WORD_W-1:CNT_W]),
      .carry_in (carry),
      .wrap     (wrap_v[i]),
      .count_o  (cnt_v[i]),
      .reload_o (rld_v[i]),
      .ctrl_o   (ctrl_v[i]),
      .ovf_o    (ovf_pulse[i]),
      .irq_o    (irq_pulse[i])
    );
  end

  assign rd_data = {ctrl_v[rd_sel], cnt_v[rd_sel]};

endmodule

// File: rtl/tmr_chain_chk.sv
module tmr_chain_chk #(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [NUM_TMR-1:0]            ovf_pulse,
  input logic [NUM_TMR-1:0]            irq_pulse,
  input logic [NUM_TMR-1:0]            chain_v,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_TMR-1:0][CNT_W-1:0] rld_v
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (ovf_pulse == '0 && irq_pulse == '0 && cnt_v == '0));

  assert_irq_with_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse & ~ovf_pulse) == '0);

  assert_head_chain_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_v[0] && !wr_en) |=> $stable(cnt_v[0]));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    assert_reload_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_pulse[i] && !$past(chain_v[i]) && !$past(wr_en)) |-> cnt_v[i] == $past(rld_v[i]));

    if (i > 0) begin : g_link
      assert_ripple_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse[i] && $past(chain_v[i])) |-> ovf_pulse[i-1]);

      assert_chain_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_v[i] && !wr_en) |=> (ovf_pulse[i-1] || $stable(cnt_v[i])));
    end
  end

endmodule

bind tmr_chain tmr_chain_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .ovf_pulse (ovf_pulse),
  .irq_pulse (irq_pulse),
  .chain_v   (chain_v),
  .cnt_v     (cnt_v),
  .rld_v     (rld_v)
);

// File: tb/sim_tmr_chain.sv
module sim_tmr_chain;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic        wr_lo = 1'b0;
  logic        wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic [3:0]  ovf_pulse;
  logic [3:0]  irq_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_chain u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .ovf_pulse(ovf_pulse), .irq_pulse(irq_pulse)
  );

  // {divider code, reload, expected clocks from start to first wrap}
  localparam logic [33:0] VEC [8] = '{
    {2'd0, 16'hFFFF, 16'd1},
    {2'd0, 16'hFFF0, 16'd16},
    {2'd1, 16'hFFFE, 16'd128},
    {2'd2, 16'hFFFF, 16'd256},
    {2'd3, 16'hFFFF, 16'd1024},
    {2'd0, 16'hFF00, 16'd256},
    {2'd3, 16'hFFFC, 16'd4096},
    {2'd2, 16'hFFF8, 16'd2048}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] sel, input logic lo, input logic hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_lo = lo; wr_hi = hi; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  task automatic wait_ovf0(output int k);
    k = 0;
    do begin
      @(posedge clk);
      #1;
      k++;
    end while (!ovf_pulse[0] && k < 70000);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0, c1;
    int k;

    repeat (3) @(posedge clk);
    #1;
    // R1: state while in reset
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 reset word", d, 32'h0);
    end
    chk("R1 strobes", {28'h0, ovf_pulse | irq_pulse}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R3 load on start, R4/R5 period, R5 reload after wrap
    for (int v = 0; v < 8; v++) begin
      bus_wr(2'd0, 1'b0, 1'b1, 32'h0);
      bus_wr(2'd0, 1'b1, 1'b1, {14'h0020, VEC[v][33:32], VEC[v][31:16]});
      rd(2'd0, d);
      if (VEC[v][15:0] != 16'd1) chk("R3 count loads reload", {16'h0, d[15:0]}, {16'h0, VEC[v][31:16]});
      wait_ovf0(k);
      chk("R4 R5 wrap period", k, {16'h0, VEC[v][15:0]});
      rd(2'd0, d);
      chk("R5 reload after wrap", {16'h0, d[15:0]}, {16'h0, VEC[v][31:16]});
    end
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);

    // R10: readback packing, unused bits zero
    bus_wr(2'd2, 1'b0, 1'b1, 32'hFFFF_0000);
    rd(2'd2, d);
    chk("R10 readback word", d, 32'h00C7_0000);
    bus_wr(2'd2, 1'b0, 1'b1, 32'h0);

    // R2: reload write does not touch a running count
    bus_wr(2'd0, 1'b1, 1'b1, 32'h0080_1000);
    repeat (3) @(posedge clk);
    bus_wr(2'd0, 1'b1, 1'b0, 32'h0000_ABCD);
    rd(2'd0, c0);
    chk("R2 count not replaced", {31'h0, c0[15:0] == 16'hABCD}, 32'h0);
    @(posedge clk);
    #1;
    rd(2'd0, c1);
    chk("R2 count keeps stepping", {16'h0, c1[15:0]}, {16'h0, c0[15:0] + 16'd1});
    // R11: rewriting control with run still 1 does not reload
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0080_0000);
    rd(2'd0, d);
    chk("R11 no reload on run rewrite", {16'h0, d[15:0]}, {16'h0, c1[15:0] + 16'd1});
    // R3: restart with only control uses stored reload
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0080_0000);
    rd(2'd0, d);
    chk("R3 restart uses stored reload", {16'h0, d[15:0]}, 32'h0000_ABCD);

    // R6: interrupt strobe follows enable bit, strobe lasts one cycle
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);
    bus_wr(2'd0, 1'b1, 1'b1, 32'h00C0_FFFE);
    wait_ovf0(k);
    chk("R6 wrap after two clocks", k, 32'd2);
    chk("R6 irq with enable", {31'h0, irq_pulse[0]}, 32'h1);
    @(posedge clk);
    #1;
    chk("R6 strobe one cycle", {31'h0, ovf_pulse[0]}, 32'h0);
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);
    bus_wr(2'd0, 1'b1, 1'b1, 32'h0080_FFFE);
    wait_ovf0(k);
    chk("R6 no irq without enable", {31'h0, irq_pulse[0]}, 32'h0);

    // R9: timer 0 chained never steps
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);
    bus_wr(2'd0, 1'b1, 1'b1, 32'h0084_1234);
    repeat (50) @(posedge clk);
    #1;
    rd(2'd0, d);
    chk("R9 chained head holds", {16'h0, d[15:0]}, 32'h0000_1234);
    chk("R9 chained head no strobe", {31'h0, ovf_pulse[0]}, 32'h0);
    bus_wr(2'd0, 1'b0, 1'b1, 32'h0);

    // R7/R8: chain of three above timer 0 at 0xFFFF
    bus_wr(2'd1, 1'b1, 1'b1, 32'h0087_FFFF);
    bus_wr(2'd2, 1'b1, 1'b1, 32'h0084_FFFF);
    bus_wr(2'd3, 1'b1, 1'b1, 32'h0084_FFFF);
    repeat (2000) @(posedge clk);
    #1;
    rd(2'd1, d);
    chk("R7 chained ignores divider", {16'h0, d[15:0]}, 32'h0000_FFFF);
    bus_wr(2'd0, 1'b1, 1'b1, 32'h0080_FFFF);
    chk("R8 no strobe on start edge", {28'h0, ovf_pulse}, 32'h0);
    @(posedge clk);
    #1;
    chk("R8 all four wrap together", {28'h0, ovf_pulse}, 32'hF);
    rd(2'd1, d);
    chk("R7 chained wraps to zero", {16'h0, d[15:0]}, 32'h0);
    rd(2'd3, d);
    chk("R9 top timer wraps to zero", {16'h0, d[15:0]}, 32'h0);
    rd(2'd0, d);
    chk("R9 head unaffected by top wrap", {16'h0, d[15:0]}, 32'h0000_FFFF);
    @(posedge clk);
    #1;
    chk("R7 only head wraps next", {28'h0, ovf_pulse}, 32'h1);
    rd(2'd1, d);
    chk("R7 chained steps once", {16'h0, d[15:0]}, 32'h1);
    rd(2'd2, d);
    chk("R7 upper chained holds", {16'h0, d[15:0]}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule